// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block merges the dedicated active-low interrupt pin and up to `PORT_W` general port pins into one wired-AND interrupt line. It brings that line into the core clock domain and turns it into a single pending-request signal for the interrupt arbiter. A port pin takes part only while its pull-up enable is set. It then behaves exactly like the dedicated pin and follows the same trigger sensitivity.

Two trigger modes exist. In edge-only mode, a high-to-low transition of the synchronized line sets a request latch. In edge-plus-level mode, that latch works the same way, and a low line also requests directly. Service entry sends a one-cycle acknowledge that clears the latch. Because the latch is free again from that point, one further falling edge can be held as pending while interrupts remain masked. A second output gives the synchronized line level, which the branch-on-interrupt-level test uses.

Top module: `irq_req_latch`

## Requirements
- R1: Reset forces `irq_pend_o`=0 and `irq_line_o`=1 and selects edge-plus-level mode, so a low line requests without any mode load.
- R2: In edge-only mode (`sens_level`=0 loaded), a line falling edge first sampled at clock edge E1 raises `irq_pend_o` after edge E3.
- R3: A latched request holds until an `svc_ack` pulse, and it reads 0 one cycle after that pulse when no new edge coincides.
- R4: A port pin whose pull-up enable bit is 1 and that is driven low pulls the combined line low and requests exactly like the dedicated pin.
- R5: A port pin whose pull-up enable bit is 0 has no effect on `irq_pend_o` or `irq_line_o`, whatever its level.
- R6: `irq_line_o` is the wired-AND of the dedicated pin and the enabled port pins, delayed by two clocks.
- R7: In edge-plus-level mode, `irq_pend_o` is 1 whenever `irq_line_o` is 0, including after an acknowledge.
- R8: In edge-plus-level mode, a one-cycle low pulse is still latched and remains pending after the line returns high.
- R9: A falling edge detected in the same cycle as `svc_ack` leaves the request set. Several edges before one acknowledge collapse into a single request.
- R10: `sens_load`=1 copies `sens_level` (1 = edge-plus-level, 0 = edge-only) into the mode register, and the new mode takes effect on the next cycle.
- R11: In edge-only mode, a line held low after an acknowledge produces no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin |
| port_pin | input | PORT_W | Port pin levels |
| port_pu_en | input | PORT_W | Per-pin pull-up enables; 1 makes the pin an interrupt source |
| sens_load | input | 1 | Load strobe for the sensitivity mode |
| sens_level | input | 1 | Mode value: 1 edge-plus-level, 0 edge-only |
| svc_ack | input | 1 | One-cycle pulse at interrupt service entry |
| irq_pend_o | output | 1 | Pending interrupt request to the arbiter |
| irq_line_o | output | 1 | Synchronized combined line level (1 = high) |

## Verification
A latch stuck at 0 would show as a missing `irq_pend_o` three clocks after a pin falls. A latch that does not clear would show one clock after `svc_ack`, as a request that stays high while the line is high. A wrong enable mask or a synchronizer of the wrong depth would appear at `irq_line_o` exactly two clocks after a pin change. A mode register that fails to load would show one clock after `sens_load`, while the line is held low.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    typedef enum logic {
        SENS_EDGE       = 1'b0,
        SENS_EDGE_LEVEL = 1'b1
    } sens_mode_e;

    localparam sens_mode_e SENS_RESET = SENS_EDGE_LEVEL;
    localparam logic       LINE_IDLE  = 1'b1;

    typedef struct packed {
        logic line;
        logic fall;
    } line_evt_t;

    function automatic logic level_req(sens_mode_e mode, logic line);
        return (mode == SENS_EDGE_LEVEL) && !line;
    endfunction

    function automatic sens_mode_e to_mode(logic bit_val);
        return bit_val ? SENS_EDGE_LEVEL : SENS_EDGE;
    endfunction

endpackage

// File: rtl/irq_src_combine.sv
module irq_src_combine #(
    parameter int PORT_W = 8
) (
    input  logic              pin_n,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] pu_en,
    output logic              line_raw
);
    logic [PORT_W-1:0] pulled_low;

    for (genvar i = 0; i < PORT_W; i++) begin : g_src
        assign pulled_low[i] = pu_en[i] & ~port_pin[i];
    end

    assign line_raw = pin_n & ~(|pulled_low);
endmodule

// File: rtl/irq_sync_edge.sv
module irq_sync_edge
    import irq_req_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_raw,
    output line_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[s] <= LINE_IDLE;
                else     sync_q[s] <= line_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[s] <= LINE_IDLE;
                else     sync_q[s] <= sync_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= LINE_IDLE;
        else     prev_q <= sync_q[LAST];
    end

    always_comb begin
        evt.line = sync_q[LAST];
        evt.fall = prev_q & ~sync_q[LAST];
    end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_evt_t  evt,
    input  logic       sens_load,
    input  logic       sens_level,
    input  logic       svc_ack,
    output sens_mode_e mode,
    output logic       latched,
    output logic       pend
);
    sens_mode_e mode_q;
    logic       latch_q;

    always_ff @(posedge clk) begin
        if (rst)            mode_q <= SENS_RESET;
        else if (sens_load) mode_q <= to_mode(sens_level);
    end

    // a new edge outranks the acknowledge so it is not lost
    always_ff @(posedge clk) begin
        if (rst)           latch_q <= 1'b0;
        else if (evt.fall) latch_q <= 1'b1;
        else if (svc_ack)  latch_q <= 1'b0;
    end

    assign mode    = mode_q;
    assign latched = latch_q;
    assign pend    = latch_q | level_req(mode_q, evt.line);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_req_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_n,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] port_pu_en,
    input  logic              sens_load,
    input  logic              sens_level,
    input  logic              svc_ack,
    output logic              irq_pend_o,
    output logic              irq_line_o
);
    logic       line_raw;
    line_evt_t  evt;
    sens_mode_e sens_q;
    logic       latch_q;
    logic       fall_det;

    irq_src_combine #(.PORT_W(PORT_W)) u_combine (
        .pin_n    (irq_pin_n),
        .port_pin (port_pin),
        .pu_en    (port_pu_en),
        .line_raw (line_raw)
    );

    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw (line_raw),
        .evt      (evt)
    );

    irq_pend_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sens_load  (sens_load),
        .sens_level (sens_level),
        .svc_ack    (svc_ack),
        .mode       (sens_q),
        .latched    (latch_q),
        .pend       (irq_pend_o)
    );

    assign fall_det   = evt.fall;
    assign irq_line_o = evt.line;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk (
    input logic clk,
    input logic rst,
    input logic svc_ack,
    input logic sens_q,
    input logic fall_det,
    input logic latch_q,
    input logic line_o,
    input logic pend_o
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!latch_q && line_o && sens_q));

    a_r2_fall_sets: assert property (@(posedge clk) disable iff (rst)
        $fell(line_o) |=> pend_o);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!latch_q && !fall_det) |=> !latch_q);

    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !svc_ack) |=> latch_q);

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (svc_ack && !fall_det) |=> !latch_q);

    a_r7_level_req: assert property (@(posedge clk) disable iff (rst)
        (sens_q && !line_o) |-> pend_o);

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (svc_ack && fall_det) |=> latch_q);
endmodule

bind irq_req_latch irq_req_latch_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .svc_ack  (svc_ack),
    .sens_q   (sens_q),
    .fall_det (fall_det),
    .latch_q  (latch_q),
    .line_o   (irq_line_o),
    .pend_o   (irq_pend_o)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         irq_pin_n = 1'b1;
    logic [W-1:0] port_pin = '1;
    logic [W-1:0] port_pu_en = '0;
    logic         sens_load = 1'b0;
    logic         sens_level = 1'b0;
    logic         svc_ack = 1'b0;
    logic         irq_pend_o;
    logic         irq_line_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_req_latch #(.PORT_W(W)) u_irq_req_latch (
        .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .port_pin(port_pin),
        .port_pu_en(port_pu_en), .sens_load(sens_load), .sens_level(sens_level),
        .svc_ack(svc_ack), .irq_pend_o(irq_pend_o), .irq_line_o(irq_line_o)
    );

    typedef struct packed {
        logic       ld;
        logic       sens;
        logic [7:0] pu;
        logic [7:0] port;
        logic       irq;
        logic       ack;
        logic [3:0] hold;
        logic       exp_pend;
        logic       exp_line;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b0,4'd3,1'b0,1'b1,4'd5},  // R5 idle
        '{1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,4'd2,1'b0,1'b0,4'd6},  // R6 line after 2
        '{1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,4'd1,1'b1,1'b0,4'd2},  // R2 pend after 3
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b0,4'd3,1'b1,1'b1,4'd3},  // R3 held
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b1,4'd1,1'b0,1'b1,4'd3},  // R3 ack clears
        '{1'b0,1'b0,8'h04,8'hFB,1'b1,1'b0,4'd3,1'b1,1'b0,4'd4},  // R4 enabled pin
        '{1'b0,1'b0,8'h04,8'hFB,1'b1,1'b1,4'd2,1'b0,1'b0,4'd11}, // R11 held low
        '{1'b0,1'b0,8'h04,8'hFF,1'b1,1'b0,4'd3,1'b0,1'b1,4'd4},  // R4 release
        '{1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,4'd3,1'b0,1'b1,4'd5},  // R5 disabled pins
        '{1'b1,1'b1,8'h00,8'h00,1'b0,1'b0,4'd2,1'b1,1'b0,4'd7},  // R7 level
        '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,4'd1,1'b1,1'b0,4'd7},  // R7 still low
        '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,4'd3,1'b1,1'b0,4'd7},  // R7 after ack
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b0,4'd2,1'b0,1'b1,4'd7},  // R7 released
        '{1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,4'd1,1'b0,1'b1,4'd8},  // R8 pulse start
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b0,4'd4,1'b1,1'b1,4'd8},  // R8 latched
        '{1'b0,1'b0,8'h00,8'hFF,1'b1,1'b1,4'd1,1'b0,1'b1,4'd8}   // R8 ack
    };

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        svc_ack = 1'b1;
        wait_n(1);
        svc_ack = 1'b0;
    endtask

    task automatic load_mode(input logic lvl);
        sens_load = 1'b1;
        sens_level = lvl;
        wait_n(1);
        sens_load = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R1 reset state and default mode
        check(irq_pend_o, 1'b0, "R1", "pend after reset");
        check(irq_line_o, 1'b1, "R1", "line after reset");
        irq_pin_n = 1'b0;
        wait_n(2);
        check(irq_pend_o, 1'b1, "R1", "default level mode");
        irq_pin_n = 1'b1;
        wait_n(3);
        pulse_ack();
        wait_n(1);
        check(irq_pend_o, 1'b0, "R1", "cleared before table");

        load_mode(1'b0);
        for (int v = 0; v < NV; v++) begin
            port_pu_en = VECS[v].pu;
            port_pin   = VECS[v].port;
            irq_pin_n  = VECS[v].irq;
            svc_ack    = VECS[v].ack;
            sens_load  = VECS[v].ld;
            sens_level = VECS[v].sens;
            wait_n(1);
            svc_ack   = 1'b0;
            sens_load = 1'b0;
            wait_n(int'(VECS[v].hold) - 1);
            check(irq_pend_o, VECS[v].exp_pend, $sformatf("R%0d", VECS[v].req), $sformatf("row %0d pend", v));
            check(irq_line_o, VECS[v].exp_line, $sformatf("R%0d", VECS[v].req), $sformatf("row %0d line", v));
        end
        port_pu_en = '0;
        port_pin   = '1;

        // R10 mode switching, R11 held low in edge-only mode
        load_mode(1'b0);
        irq_pin_n = 1'b0;
        wait_n(3);
        check(irq_pend_o, 1'b1, "R10", "edge mode latched");
        pulse_ack();
        check(irq_pend_o, 1'b0, "R11", "held low after ack");
        load_mode(1'b1);
        check(irq_pend_o, 1'b1, "R10", "level mode one cycle after load");
        load_mode(1'b0);
        check(irq_pend_o, 1'b0, "R10", "edge mode one cycle after load");
        irq_pin_n = 1'b1;
        wait_n(3);

        // R9 edge coinciding with acknowledge
        irq_pin_n = 1'b0;
        wait_n(2);
        svc_ack = 1'b1;
        wait_n(1);
        svc_ack = 1'b0;
        check(irq_pend_o, 1'b1, "R9", "edge wins over ack");
        irq_pin_n = 1'b1;
        wait_n(3);
        pulse_ack();
        check(irq_pend_o, 1'b0, "R9", "cleared after ack");
        for (int p = 0; p < 2; p++) begin
            irq_pin_n = 1'b0;
            wait_n(1);
            irq_pin_n = 1'b1;
            wait_n(4);
            check(irq_pend_o, 1'b1, "R9", $sformatf("pulse %0d pending", p));
        end
        pulse_ack();
        wait_n(3);
        check(irq_pend_o, 1'b0, "R9", "two pulses one request");

        // R1 reset clears a pending request
        irq_pin_n = 1'b0;
        wait_n(1);
        irq_pin_n = 1'b1;
        wait_n(4);
        check(irq_pend_o, 1'b1, "R1", "pending before reset");
        rst = 1'b1;
        wait_n(1);
        rst = 1'b0;
        check(irq_pend_o, 1'b0, "R1", "reset clears request");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule